// File: doc/BRIEF.md
# Multiband pulse-swallow frequency divider

This block divides its input clock by a programmable integer ratio N and emits one pulse, one clock wide, per division cycle. It is built as a pulse-swallow divider with three parts. A dual-modulus prescaler is built around a divide-by-2/3 cell. A 6-bit loadable swallow counter sets the number of prescaler periods that use the larger modulus. A 7-bit loadable program counter sets the total number of prescaler periods in one output cycle.

A band input picks the prescaler modulus pair. The low band uses 32 and 33. The high band uses 47 and 48. The ratio is N = M·P + S, where M is the smaller modulus of the selected band, P is the program value and S is the swallow value. The band, P and S inputs are sampled only at a division-cycle boundary. A configuration that cannot be divided correctly is refused and reported. The block is used as the feedback divider of a channelised synthesizer, where a step of one in S moves the output by one channel.

Top module: `ps_freq_div`

## Requirements
- R1: While rst_ni is low, div_o and cfg_err_o are 0. The first rising clock edge after reset release latches the inputs, and the first div_o pulse appears N cycles later: it is high during the N-th cycle after that edge.
- R2: With band_hi_i = 0, successive div_o pulses are exactly 32·P + S clock cycles apart.
- R3: With band_hi_i = 1, successive div_o pulses are exactly 47·P + S clock cycles apart.
- R4: div_o is high for exactly one clock cycle per division cycle.
- R5: band_hi_i, prog_i and swal_i are sampled only on the clock edge that ends a div_o cycle, or on the first edge after reset. A change at any other time does not alter the division cycle in progress.
- R6: A load is legal when P ≥ 1, S ≤ P, and S ≤ 31 (low band) or S ≤ 47 (high band). On an illegal load, cfg_err_o is 1 for the whole following division cycle and the previously accepted configuration stays in force. The default after reset is low band, P = 1, S = 0.
- R7: A legal load sets cfg_err_o to 0 for the following division cycle.
- R8: Inside each division cycle, the prescaler uses its larger modulus while the swallow count is nonzero and its smaller modulus afterwards. The swallow count never exceeds the program count.
- R9: Extreme legal settings divide correctly: S = P, the largest swallow value of each band, and P = 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| band_hi_i | input | 1 | 0: modulus pair 32/33, 1: modulus pair 47/48 |
| prog_i | input | 7 | Program value P |
| swal_i | input | 6 | Swallow value S |
| div_o | output | 1 | One-cycle pulse per division cycle |
| cfg_err_o | output | 1 | Last boundary load was illegal and was refused |

## Verification
The inputs are sampled on one edge only: the edge that closes the pulse cycle. Any change of band, P or S is therefore tested only if the stimulus is timed against div_o. The bench waits until it sees div_o high at a falling edge and drives the new configuration there, so the very next rising edge is a boundary. To check the mid-cycle case, it changes the inputs a few cycles into a division cycle. It then confirms that the interval being timed keeps the old ratio and that the next interval takes the new one. Illegal loads are applied at a boundary in the same way. The bench then times the following interval, which must still show the last accepted ratio, and checks that cfg_err_o stays high through it.

// File: rtl/dv_pkg.sv
package dv_pkg;
  localparam int unsigned PW = 7;
  localparam int unsigned SW = 6;

  typedef struct packed {
    logic          hi;
    logic [PW-1:0] p;
    logic [SW-1:0] s;
  } cfg_t;
endpackage

// File: rtl/dv_load_cnt.sv
module dv_load_cnt #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= val_i;
    else if (dec_i && cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign cnt_o = cnt_q;

  a_r8_load_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(val_i));
  a_r8_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/dv_prescaler.sv
module dv_prescaler #(
  parameter int unsigned MOD_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic             last_o
);
  localparam int unsigned HW = MOD_W - 1;

  // 2/3 cell runs mod_i/2 periods; the final one is 3 long when mod_i is odd
  logic [HW-1:0] per_q;
  logic [1:0]    cell_q;
  logic          odd_q;
  logic [HW-1:0] half;

  assign half = mod_i[MOD_W-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      cell_q <= '0;
      odd_q  <= 1'b0;
    end else if (load_i) begin
      per_q  <= half - HW'(1);
      odd_q  <= mod_i[0];
      cell_q <= (half == HW'(1) && mod_i[0]) ? 2'd2 : 2'd1;
    end else if (cell_q == 2'd0) begin
      if (per_q != '0) begin
        per_q  <= per_q - HW'(1);
        cell_q <= (per_q == HW'(1) && odd_q) ? 2'd2 : 2'd1;
      end
    end else begin
      cell_q <= cell_q - 2'd1;
    end
  end

  assign last_o = (cell_q == 2'd0) && (per_q == '0);

  a_r8_no_short_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !last_o);
  a_r8_cell_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_q != 2'd3);
endmodule

// File: rtl/ps_freq_div.sv
module ps_freq_div
  import dv_pkg::*;
#(
  parameter int unsigned M_LO_BAND = 32,
  parameter int unsigned M_HI_BAND = 47,
  parameter int unsigned S_MAX_LO  = 31,
  parameter int unsigned S_MAX_HI  = 47
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          band_hi_i,
  input  logic [PW-1:0] prog_i,
  input  logic [SW-1:0] swal_i,
  output logic          div_o,
  output logic          cfg_err_o
);
  localparam int unsigned MOD_W = $clog2(M_HI_BAND + 2);
  localparam logic [SW-1:0] SMAX_L = SW'(S_MAX_LO);
  localparam logic [SW-1:0] SMAX_H = SW'(S_MAX_HI);

  cfg_t          cfg_q, cfg_in, cfg_nx;
  logic          started_q, err_q;
  logic          legal, pre_last, end_cyc, bnd, pre_load;
  logic          hi_n, swal_nz;
  logic [MOD_W-1:0] mod_nx;
  logic [SW-1:0] s_cnt;
  logic [PW-1:0] p_cnt;

  assign cfg_in = '{hi: band_hi_i, p: prog_i, s: swal_i};
  assign legal  = (prog_i != '0) && (PW'(swal_i) <= prog_i) &&
                  (swal_i <= (band_hi_i ? SMAX_H : SMAX_L));
  assign cfg_nx = legal ? cfg_in : cfg_q;

  assign end_cyc  = started_q && pre_last && (p_cnt == PW'(1));
  assign bnd      = !started_q || end_cyc;
  assign pre_load = !started_q || pre_last;

  // modulus of the prescaler period about to start
  always_comb begin
    if (bnd) begin
      hi_n    = cfg_nx.hi;
      swal_nz = (cfg_nx.s != '0);
    end else begin
      hi_n    = cfg_q.hi;
      swal_nz = (s_cnt > SW'(1));
    end
    mod_nx = (hi_n ? MOD_W'(M_HI_BAND) : MOD_W'(M_LO_BAND)) + MOD_W'(swal_nz);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      err_q     <= 1'b0;
      cfg_q     <= '{hi: 1'b0, p: PW'(1), s: '0};
    end else if (bnd) begin
      started_q <= 1'b1;
      err_q     <= !legal;
      cfg_q     <= cfg_nx;
    end
  end

  dv_prescaler #(.MOD_W(MOD_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(pre_load),
    .mod_i (mod_nx),
    .last_o(pre_last)
  );

  dv_load_cnt #(.W(SW)) u_swal (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(bnd),
    .val_i (cfg_nx.s),
    .dec_i (started_q && pre_last),
    .cnt_o (s_cnt)
  );

  dv_load_cnt #(.W(PW)) u_prog (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(bnd),
    .val_i (cfg_nx.p),
    .dec_i (started_q && pre_last),
    .cnt_o (p_cnt)
  );

  assign div_o     = end_cyc;
  assign cfg_err_o = err_q;

  a_r1_quiet_before_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> (!div_o && !cfg_err_o));
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);
  a_r6_keep_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd && !legal) |=> (cfg_q == $past(cfg_q)) && cfg_err_o);
  a_r8_swal_le_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> (PW'(s_cnt) <= p_cnt));
endmodule

// File: tb/ps_freq_div_tb.sv
module ps_freq_div_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       band_hi = 1'b0;
  logic [6:0] prog = 7'd1;
  logic [5:0] swal = 6'd0;
  logic       div_w, err_w;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5ns clk = ~clk;

  ps_freq_div u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .band_hi_i(band_hi),
    .prog_i   (prog),
    .swal_i   (swal),
    .div_o    (div_w),
    .cfg_err_o(err_w)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a falling edge; counts cycles until div_o is seen high
  task automatic measure(input int exp_n, input logic exp_err, input string req);
    int cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        check(err_w == exp_err, exp_err ? "R6 err set" : "R7 err clear", int'(err_w), int'(exp_err));
        if (exp_n > 1) check(div_w == 1'b0, "R4 pulse width", int'(div_w), 0);
      end
    end while (!div_w && cnt < 8000);
    if (cnt >= 8000) check(1'b0, "watchdog interval", cnt, exp_n);
    else check(cnt == exp_n, req, cnt, exp_n);
    check(err_w == exp_err, exp_err ? "R6 err held" : "R7 err held", int'(err_w), int'(exp_err));
  endtask

  task automatic apply(input logic hi, input int p, input int s,
                       input int exp_n, input logic exp_err, input string req);
    band_hi = hi;
    prog    = 7'(p);
    swal    = 6'(s);
    measure(exp_n, exp_err, req);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(div_w == 1'b0, "R1 div in reset", int'(div_w), 0);
    check(err_w == 1'b0, "R1 err in reset", int'(err_w), 0);
    band_hi = 1'b0; prog = 7'd1; swal = 6'd0;
    rst_n = 1'b1;
    measure(32, 1'b0, "R1 first pulse");

    // R2/R3 sweep of small P with every legal S
    for (int hi = 0; hi < 2; hi++) begin
      for (int p = 1; p <= 12; p++) begin
        for (int s = 0; s <= p; s++) begin
          apply(1'(hi), p, s, (hi != 0 ? 47 : 32) * p + s, 1'b0,
                hi != 0 ? "R3 high band ratio" : "R2 low band ratio");
        end
      end
    end

    // R9 extremes
    apply(1'b0, 31, 31, 32*31 + 31, 1'b0, "R9 low S=P=31");
    apply(1'b0, 127, 31, 32*127 + 31, 1'b0, "R9 low P=127 S=31");
    apply(1'b1, 47, 47, 47*47 + 47, 1'b0, "R9 high S=P=47");
    apply(1'b1, 127, 47, 47*127 + 47, 1'b0, "R9 high P=127 S=47");
    apply(1'b1, 127, 0, 47*127, 1'b0, "R9 high P=127 S=0");

    // R5 mid-cycle change is ignored until the boundary
    band_hi = 1'b0; prog = 7'd3; swal = 6'd1;
    begin
      int cnt = 0;
      do begin
        @(negedge clk);
        cnt++;
        if (cnt == 10) begin
          band_hi = 1'b1; prog = 7'd2; swal = 6'd2;
        end
      end while (!div_w && cnt < 8000);
      check(cnt == 97, "R5 mid-cycle change ignored", cnt, 97);
    end
    measure(47*2 + 2, 1'b0, "R5 new config after boundary");

    // R6 illegal loads keep the last accepted ratio
    apply(1'b0, 2, 1, 65, 1'b0, "R2 before illegal");
    apply(1'b0, 2, 3, 65, 1'b1, "R6 S>P refused");
    apply(1'b0, 40, 32, 65, 1'b1, "R6 S>31 low refused");
    apply(1'b0, 0, 0, 65, 1'b1, "R6 P=0 refused");
    apply(1'b1, 60, 48, 65, 1'b1, "R6 S>47 high refused");
    apply(1'b1, 1, 1, 48, 1'b0, "R7 legal load recovers");
    apply(1'b0, 40, 31, 32*40 + 31, 1'b0, "R7 low max S accepted");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule